// File: doc/BRIEF.md
# Split-word access bridge for 64-bit registers

This block lets a bus that moves 32 bits at a time reach a bank of 64-bit registers. One holding register inside the bridge joins two bus writes into a single 64-bit register write. The same holding register splits one 64-bit register read into two bus reads. Data is little-endian: the bus word whose address has bit 2 clear carries bits 31:0 of the register, and the word with bit 2 set carries bits 63:32. Register addresses advance in steps of 0x40. The bridge looks only at bit 2 and passes the other address bits through unchanged.

The bus master writes the low word first. That write goes into the holding register and nothing else. The high-word write then commits both halves as one 64-bit write. For a read, the master reads the low word first. The bridge fetches the full register, returns bits 31:0, and parks bits 63:32 in the holding register. The following high-word read is answered from the holding register without touching the bank. Because reads and writes share the holding register, a low-word read placed between the two halves of a write replaces the pending lower half.

Control is a Moore state machine with four states:
- `ST_IDLE` accepts a new access.
- `ST_COMMIT` drives the one-cycle register write strobe.
- `ST_FETCH` drives the one-cycle register read strobe and expects the bank to answer in that same cycle.
- `ST_REPLY` presents the bus read data.

The transitions are:
- `ST_IDLE` to `ST_COMMIT` on a high-word write.
- `ST_IDLE` to `ST_FETCH` on a low-word read.
- `ST_IDLE` to `ST_REPLY` on a high-word read.
- `ST_IDLE` back to itself on a low-word write or when there is no strobe.
- `ST_FETCH` to `ST_REPLY`.
- `ST_COMMIT` to `ST_IDLE`.
- `ST_REPLY` to `ST_IDLE`.

`bus_ready` is high only in `ST_IDLE`.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset the holding register is zero, `bus_ready` is 1, and `reg_wr`, `reg_rd` and `bus_rvalid` are 0. A high-word read issued right after reset returns 0.
- R2: An accepted write with address bit 2 equal to 0 loads `bus_wdata` into the holding register and produces no strobe on `reg_wr`, `reg_rd` or `bus_rvalid`. `bus_ready` stays 1.
- R3: An accepted write with address bit 2 equal to 1 raises `reg_wr` in the cycle after acceptance. In that cycle `reg_wdata[63:32]` is the new bus data, `reg_wdata[31:0]` is the holding register, and `reg_addr` is the bus address with bit 2 cleared.
- R4: An accepted read with address bit 2 equal to 1 raises `bus_rvalid` in the cycle after acceptance. `bus_rdata` then equals the holding register, and `reg_rd` stays 0.
- R5: An accepted read with address bit 2 equal to 0 raises `reg_rd` in the cycle after acceptance, with `reg_addr` equal to the bus address with bit 2 cleared. In the next cycle `bus_rvalid` is 1 with `bus_rdata` equal to `reg_rdata[31:0]`, and the holding register takes `reg_rdata[63:32]`.
- R6: A low-word read issued between the two halves of a write replaces the pending lower half. The commit then carries the fetched upper word in bits 31:0.
- R7: `bus_ready` is 0 in every state other than `ST_IDLE`. Strobes presented while it is 0 are ignored and leave the holding register unchanged.
- R8: When `bus_wr` and `bus_rd` are both 1 on an accepted cycle, the write is performed and the read is dropped, so no `bus_rvalid` follows.
- R9: `reg_wr`, `reg_rd` and `bus_rvalid` are each single-cycle pulses, and no two of them are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Bus byte address; bit 2 selects the upper word |
| bus_wr | input | 1 | Bus write strobe, taken when `bus_ready` is 1 |
| bus_rd | input | 1 | Bus read strobe, taken when `bus_ready` is 1 |
| bus_wdata | input | HW | Bus write data |
| bus_ready | output | 1 | High when a new access can be taken |
| bus_rdata | output | HW | Bus read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | One-cycle read-data pulse |
| reg_addr | output | AW | Register address, bit 2 always clear |
| reg_wr | output | 1 | One-cycle 64-bit register write strobe |
| reg_rd | output | 1 | One-cycle 64-bit register read strobe |
| reg_wdata | output | 2*HW | 64-bit register write data |
| reg_rdata | input | 2*HW | 64-bit register read data, valid while `reg_rd` is 1 |

## Verification
The hardest situation to reach is a register access arriving in the middle of another access's use of the holding register. The main cases are a low-word read between the two write halves, and a strobe presented while the bridge is busy. Random traffic produces these orderings only now and then. Directed sequences therefore force them: an interleaved fetch before a commit, and a low-word write injected during `ST_COMMIT` and then read back through a high-word read. A seeded random stream of mixed accesses across 64 registers then checks every reply and commit against a bench model of the holding register and the bank.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_FETCH  = 2'd2,
        ST_REPLY  = 2'd3
    } wrb_state_t;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_LATCH_LO  = 3'd1,
        OP_COMMIT_HI = 3'd2,
        OP_READ_LO   = 3'd3,
        OP_READ_HI   = 3'd4
    } wrb_op_t;

    // A write wins over a read presented in the same cycle.
    function automatic wrb_op_t wrb_decode(input logic wr, input logic rd, input logic upper);
        if (wr) return upper ? OP_COMMIT_HI : OP_LATCH_LO;
        if (rd) return upper ? OP_READ_HI : OP_READ_LO;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/wrb_fsm.sv
module wrb_fsm
    import wrb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wrb_op_t    op_i,
    output wrb_state_t state_o,
    output logic       ready_o,
    output logic       reg_wr_o,
    output logic       reg_rd_o,
    output logic       rvalid_o
);

    wrb_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                case (op_i)
                    OP_COMMIT_HI: state_d = ST_COMMIT;
                    OP_READ_LO:   state_d = ST_FETCH;
                    OP_READ_HI:   state_d = ST_REPLY;
                    default:      state_d = ST_IDLE;
                endcase
            end
            ST_COMMIT: state_d = ST_IDLE;
            ST_FETCH:  state_d = ST_REPLY;
            ST_REPLY:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready_o  = 1'b0;
        reg_wr_o = 1'b0;
        reg_rd_o = 1'b0;
        rvalid_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   ready_o  = 1'b1;
            ST_COMMIT: reg_wr_o = 1'b1;
            ST_FETCH:  reg_rd_o = 1'b1;
            ST_REPLY:  rvalid_o = 1'b1;
        endcase
    end

    assign state_o = state_q;

    // R9: strobes never overlap
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_o, reg_rd_o, rvalid_o}));

    // R9: register write strobe lasts one cycle
    p_wr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);

    // R5: a fetch is always followed by the bus reply
    p_fetch_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |=> rvalid_o);

    // R3: an accepted upper-word write commits on the next cycle
    p_accept_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_COMMIT_HI) |=> reg_wr_o);

endmodule

// File: rtl/wrb_hold.sv
module wrb_hold #(
    parameter int HW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_bus_i,
    input  logic [HW-1:0] bus_d_i,
    input  logic          ld_reg_i,
    input  logic [HW-1:0] reg_d_i,
    output logic [HW-1:0] q_o
);

    logic [HW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hold_q <= '0;
        else if (ld_reg_i) hold_q <= reg_d_i;
        else if (ld_bus_i) hold_q <= bus_d_i;
    end

    assign q_o = hold_q;

    // R6: the two writers of the shared holding register never collide
    p_hold_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_bus_i && ld_reg_i));

endmodule

// File: rtl/wrb_capture.sv
module wrb_capture
    import wrb_pkg::*;
#(
    parameter int AW  = 12,
    parameter int HW  = 32,
    parameter int SEL = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  wrb_op_t         op_i,
    input  logic [AW-1:0]   bus_addr_i,
    input  logic [HW-1:0]   bus_wdata_i,
    input  logic [HW-1:0]   hold_i,
    input  logic            fetch_i,
    input  logic [HW-1:0]   reg_rdata_lo_i,
    output logic [AW-1:0]   reg_addr_o,
    output logic [2*HW-1:0] reg_wdata_o,
    output logic [HW-1:0]   bus_rdata_o
);

    localparam logic [AW-1:0] LANE_BIT = AW'(1) << SEL;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_addr_o  <= '0;
            reg_wdata_o <= '0;
            bus_rdata_o <= '0;
        end else begin
            if (op_i == OP_COMMIT_HI || op_i == OP_READ_LO)
                reg_addr_o <= bus_addr_i & ~LANE_BIT;
            if (op_i == OP_COMMIT_HI)
                reg_wdata_o <= {bus_wdata_i, hold_i};
            if (op_i == OP_READ_HI)
                bus_rdata_o <= hold_i;
            else if (fetch_i)
                bus_rdata_o <= reg_rdata_lo_i;
        end
    end

    // R3: register-side address never carries the word-select bit
    p_lane_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_COMMIT_HI || op_i == OP_READ_LO) |=> !reg_addr_o[SEL]);

endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
    import wrb_pkg::*;
#(
    parameter int AW = 12,
    parameter int HW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [HW-1:0]   bus_wdata,
    output logic            bus_ready,
    output logic [HW-1:0]   bus_rdata,
    output logic            bus_rvalid,
    output logic [AW-1:0]   reg_addr,
    output logic            reg_wr,
    output logic            reg_rd,
    output logic [2*HW-1:0] reg_wdata,
    input  logic [2*HW-1:0] reg_rdata
);

    localparam int DW  = 2 * HW;
    localparam int SEL = $clog2(HW / 8);

    wrb_op_t       op;
    wrb_state_t    state;
    logic [HW-1:0] hold;

    assign op = bus_ready ? wrb_decode(bus_wr, bus_rd, bus_addr[SEL]) : OP_NONE;

    wrb_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op),
        .state_o  (state),
        .ready_o  (bus_ready),
        .reg_wr_o (reg_wr),
        .reg_rd_o (reg_rd),
        .rvalid_o (bus_rvalid)
    );

    wrb_hold #(.HW(HW)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_bus_i (op == OP_LATCH_LO),
        .bus_d_i  (bus_wdata),
        .ld_reg_i (reg_rd),
        .reg_d_i  (reg_rdata[DW-1:HW]),
        .q_o      (hold)
    );

    wrb_capture #(.AW(AW), .HW(HW), .SEL(SEL)) u_capture (
        .clk            (clk),
        .rst_n          (rst_n),
        .op_i           (op),
        .bus_addr_i     (bus_addr),
        .bus_wdata_i    (bus_wdata),
        .hold_i         (hold),
        .fetch_i        (reg_rd),
        .reg_rdata_lo_i (reg_rdata[HW-1:0]),
        .reg_addr_o     (reg_addr),
        .reg_wdata_o    (reg_wdata),
        .bus_rdata_o    (bus_rdata)
    );

    // R7: ready only in the idle state
    p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready == (state == ST_IDLE));

    // R3: every commit traces back to an accepted upper-word write
    p_commit_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(bus_ready && bus_wr && bus_addr[SEL]));

    // R2: a lower-word write leaves the bridge ready
    p_latch_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && bus_wr && !bus_addr[SEL]) |=> bus_ready);

endmodule

// File: tb/wide_reg_bridge_bench.sv
`timescale 1ns/1ps
module wide_reg_bridge_bench;

    localparam int AW = 12;
    localparam int HW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [HW-1:0]   bus_wdata = '0;
    logic            bus_ready;
    logic [HW-1:0]   bus_rdata;
    logic            bus_rvalid;
    logic [AW-1:0]   reg_addr;
    logic            reg_wr;
    logic            reg_rd;
    logic [2*HW-1:0] reg_wdata;
    logic [2*HW-1:0] reg_rdata;

    always #2 clk = ~clk;

    wide_reg_bridge #(.AW(AW), .HW(HW)) u_wide_reg_bridge (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [63:0] init_pat(input int i);
        return {32'h1000_0000 + 32'(i) * 32'h0001_0203, 32'hC0DE_0000 ^ (32'(i) * 32'h0000_1111)};
    endfunction

    // Register bank stand-in, read in the same cycle as the strobe
    logic [63:0] bank [64];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) bank[i] <= init_pat(i);
        end else if (reg_wr) begin
            bank[reg_addr[11:6]] <= reg_wdata;
        end
    end
    assign reg_rdata = bank[reg_addr[11:6]];

    // Bench model
    logic [31:0] latch_m;
    logic [63:0] mem_m [64];
    logic [63:0] last_commit;
    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input logic ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic access(input logic wr, input logic rd, input logic [5:0] idx,
                          input logic upper, input logic [31:0] d);
        logic [AW-1:0] ea;
        ea = {idx, 6'b000000};
        while (!bus_ready) @(negedge clk);
        bus_addr  = {idx, 3'b000, upper, 2'b00};
        bus_wr    = wr;
        bus_rd    = rd;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        if (wr && !upper) begin
            chk(!reg_wr && !reg_rd && !bus_rvalid && bus_ready, "R2",
                {reg_wr, reg_rd, bus_rvalid, bus_ready}, 64'h1);
            if (rd) chk(!bus_rvalid, "R8", bus_rvalid, 0);
            latch_m = d;
            if (rd) begin
                @(negedge clk);
                chk(!bus_rvalid, "R8", bus_rvalid, 0);
            end
        end else if (wr) begin
            chk(reg_wr == 1'b1, "R3", reg_wr, 1);
            chk(reg_addr == ea, "R3", reg_addr, ea);
            chk(reg_wdata == {d, latch_m}, "R3", reg_wdata, {d, latch_m});
            last_commit = reg_wdata;
            mem_m[idx] = {d, latch_m};
            @(negedge clk);
            chk(!reg_wr && !bus_rvalid, "R9", reg_wr, 0);
        end else if (upper) begin
            chk(bus_rvalid && !reg_rd, "R4", {bus_rvalid, reg_rd}, 64'h2);
            chk(bus_rdata == latch_m, "R4", bus_rdata, latch_m);
        end else begin
            chk(reg_rd == 1'b1 && reg_addr == ea, "R5", {reg_rd, reg_addr}, {1'b1, ea});
            @(negedge clk);
            chk(bus_rvalid == 1'b1, "R5", bus_rvalid, 1);
            chk(bus_rdata == mem_m[idx][31:0], "R5", bus_rdata, mem_m[idx][31:0]);
            latch_m = mem_m[idx][63:32];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 0);
        summary();
        $finish;
    end

    initial begin
        logic [63:0] saved;
        void'($urandom(32'd20240611));
        latch_m = '0;
        last_commit = '0;
        for (int i = 0; i < 64; i++) mem_m[i] = init_pat(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(bus_ready && !reg_wr && !reg_rd && !bus_rvalid, "R1",
            {bus_ready, reg_wr, reg_rd, bus_rvalid}, 64'h8);
        access(1'b0, 1'b1, 6'd0, 1'b1, 32'h0);
        chk(bus_rdata == 32'h0, "R1", bus_rdata, 0);

        // R2/R3: plain two-half write, then read back both halves (R5, R4)
        access(1'b1, 1'b0, 6'd9, 1'b0, 32'hDEAD_BEEF);
        access(1'b1, 1'b0, 6'd9, 1'b1, 32'h0BAD_F00D);
        access(1'b0, 1'b1, 6'd9, 1'b0, 32'h0);
        access(1'b0, 1'b1, 6'd9, 1'b1, 32'h0);
        chk(bus_rdata == 32'h0BAD_F00D, "R4", bus_rdata, 32'h0BAD_F00D);

        // R6: read between the two write halves replaces the pending lower half
        access(1'b1, 1'b0, 6'd3, 1'b0, 32'hAAAA_0001);
        access(1'b0, 1'b1, 6'd7, 1'b0, 32'h0);
        saved = mem_m[7];
        access(1'b1, 1'b0, 6'd3, 1'b1, 32'hBBBB_0002);
        chk(last_commit == {32'hBBBB_0002, saved[63:32]}, "R6",
            last_commit, {32'hBBBB_0002, saved[63:32]});

        // R7: strobe during commit is ignored
        access(1'b1, 1'b0, 6'd5, 1'b0, 32'h1234_5678);
        bus_addr = {6'd5, 6'b000100};
        bus_wr = 1'b1;
        bus_wdata = 32'h9ABC_DEF0;
        @(negedge clk);
        chk(reg_wr == 1'b1 && bus_ready == 1'b0, "R7", {reg_wr, bus_ready}, 64'h2);
        chk(reg_wdata == {32'h9ABC_DEF0, 32'h1234_5678}, "R3", reg_wdata, {32'h9ABC_DEF0, 32'h1234_5678});
        mem_m[5] = {32'h9ABC_DEF0, 32'h1234_5678};
        bus_addr = {6'd5, 6'b000000};
        bus_wdata = 32'hFFFF_0000;
        @(negedge clk);
        bus_wr = 1'b0;
        chk(!reg_wr, "R9", reg_wr, 0);
        access(1'b0, 1'b1, 6'd5, 1'b1, 32'h0);
        chk(bus_rdata == 32'h1234_5678, "R7", bus_rdata, 32'h1234_5678);

        // R8: both strobes at once, write wins
        access(1'b1, 1'b1, 6'd2, 1'b0, 32'h5555_AAAA);
        access(1'b0, 1'b1, 6'd2, 1'b1, 32'h0);
        chk(bus_rdata == 32'h5555_AAAA, "R8", bus_rdata, 32'h5555_AAAA);

        // Seeded random mix of all four access kinds
        for (int n = 0; n < 400; n++) begin
            int kind;
            logic [5:0] ridx;
            logic [31:0] rd32;
            kind = int'($urandom % 4);
            ridx = 6'($urandom % 64);
            rd32 = $urandom;
            case (kind)
                0: access(1'b1, 1'b0, ridx, 1'b0, rd32);
                1: access(1'b1, 1'b0, ridx, 1'b1, rd32);
                2: access(1'b0, 1'b1, ridx, 1'b0, 32'h0);
                default: access(1'b0, 1'b1, ridx, 1'b1, 32'h0);
            endcase
        end

        @(negedge clk);
        summary();
        $finish;
    end

endmodule